// File: doc/BRIEF.md
# Single-Wire Debug Acknowledge Handshake

This block is the target end of a one-wire background debug link. The host sends a command byte and then a memory address, one bit per strobe. When the command byte is the memory-read code, the block raises a request to the CPU and holds the address for it. The CPU finds a free slot in its instruction stream, performs the access by cycle stealing, returns the byte and signals completion.

The block acknowledges the command only after the CPU has finished the access. It leaves the open-drain pin undriven for a minimum quiet interval after the last command bit. It then pulls the pin low for a fixed number of debug-clock cycles and ends with one cycle of active high drive, which gives a fast rising edge. If the CPU enters stop mode before the access runs, the command is dropped, no acknowledge appears, and a status code records the discard.

Top module: `dbg_ack_top`

## Requirements
- R1: A frame is CODE_W (8) command bits followed by ADDR_W address bits. Each is taken from `pin_in` on a cycle with `bit_stb` high, most significant bit first. If the command byte equals READ_CODE (default 8'h39), `cpu_req` is high in the cycle after the edge that takes the last bit, and `cpu_addr` carries the address.
- R2: `cpu_req` stays high until the CPU reports completion with `cpu_done`, and is low from the next cycle on.
- R3: `rd_byte` takes `cpu_rdata` on the completion edge. It then stays unchanged until a later read completes, including across frames with other codes.
- R4: The first low cycle of the acknowledge is at edge max(E0+MIN_DLY, Ed). E0 is the edge that takes the last command bit, Ed is the edge that samples `cpu_done`, and MIN_DLY defaults to 32. Before that edge neither drive enable is set.
- R5: `pin_drive_low` is high for exactly LOW_W (16) cycles. `pin_drive_high` is then high for exactly one cycle, after which both enables are low.
- R6: `pin_drive_low` and `pin_drive_high` are never high in the same cycle.
- R7: A `cpu_stop` seen while a request is pending and `cpu_done` is low discards the command. `cpu_req` falls in the next cycle and no acknowledge follows.
- R8: `cmd_status` is 3'b000 after reset and after each completed read. It is 3'b001 after a discard and keeps that value until a later read completes.
- R9: A frame whose command byte is not READ_CODE raises no request and gives no acknowledge.
- R10: Bit strobes that arrive while a command is in progress are ignored. The next frame after the handshake is decoded from its own bits alone.
- R11: A synchronous active-high `rst` clears the pending request, sets `cmd_status` to 3'b000 and releases both pin drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_stb | input | 1 | One-cycle strobe marking a valid host bit |
| pin_in | input | 1 | Sampled pin level (host bit value) |
| cpu_done | input | 1 | CPU has finished the requested access |
| cpu_stop | input | 1 | CPU is entering stop mode |
| cpu_rdata | input | 8 | Byte read by the CPU |
| pin_drive_low | output | 1 | Enable for the pull-low driver on the pin |
| pin_drive_high | output | 1 | Enable for the speed-up high driver on the pin |
| cpu_req | output | 1 | Memory-read request to the CPU |
| cpu_addr | output | ADDR_W | Address of the requested read |
| rd_byte | output | 8 | Byte captured at completion |
| cmd_status | output | 3 | Command status code |

## Verification
Reads are run with a CPU that answers quickly and with one that answers slowly. The first case shows the quiet interval setting the acknowledge edge, and the second shows completion setting it. A read cut short by stop mode and a frame with a foreign code must both leave the pin idle. They differ in the status they leave: the discard leaves 3'b001, and the foreign code leaves the status unchanged. Stray strobes during a pending read are followed by a frame with a new address, which shows whether any of those bits reached the shifter.

// File: rtl/dbg_ack_pkg.sv
package dbg_ack_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_LOW   = 2'd2,
        ST_SPEED = 2'd3
    } ack_st_e;

    localparam logic [2:0] STAT_OK      = 3'b000;
    localparam logic [2:0] STAT_DISCARD = 3'b001;
endpackage

// File: rtl/dbg_cmd_shift.sv
module dbg_cmd_shift #(
    parameter int CODE_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_en,
    input  logic              bit_stb,
    input  logic              bit_val,
    output logic              frame_vld,
    output logic [CODE_W-1:0] frame_code,
    output logic [ADDR_W-1:0] frame_addr
);
    localparam int FRAME_W = CODE_W + ADDR_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [FRAME_W-1:0] sreg;
        logic [CNT_W-1:0]   cnt;
    } shift_t;

    shift_t st_d, st_q;
    logic [FRAME_W-1:0] word_nxt;
    logic take;
    logic last;

    always_comb begin
        st_d     = st_q;
        take     = bit_stb && accept_en;
        word_nxt = {st_q.sreg[FRAME_W-2:0], bit_val};
        last     = take && (st_q.cnt == CNT_W'(FRAME_W - 1));
        if (take) begin
            st_d.sreg = word_nxt;
            st_d.cnt  = last ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign frame_vld  = last;
    assign frame_code = word_nxt[FRAME_W-1 -: CODE_W];
    assign frame_addr = word_nxt[ADDR_W-1:0];
endmodule

// File: rtl/dbg_ack_ctrl.sv
module dbg_ack_ctrl
    import dbg_ack_pkg::*;
#(
    parameter int          CODE_W    = 8,
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 8,
    parameter logic [7:0]  READ_CODE = 8'h39,
    parameter int          MIN_DLY   = 32,
    parameter int          LOW_W     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_vld,
    input  logic [CODE_W-1:0] frame_code,
    input  logic [ADDR_W-1:0] frame_addr,
    input  logic              cpu_done,
    input  logic              cpu_stop,
    input  logic [DATA_W-1:0] cpu_rdata,
    output logic              accept_en,
    output logic              drive_low,
    output logic              drive_high,
    output logic              cpu_req,
    output logic [ADDR_W-1:0] cpu_addr,
    output logic [DATA_W-1:0] rd_byte,
    output logic [2:0]        status
);
    localparam int SPAN  = (MIN_DLY > LOW_W) ? MIN_DLY : LOW_W;
    localparam int CNT_W = $clog2(SPAN + 1);

    typedef struct packed {
        ack_st_e           st;
        logic [CNT_W-1:0]  cnt;
        logic              req;
        logic              done_seen;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] rdata;
        logic [2:0]        status;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic done_now;

    always_comb begin
        c_d      = c_q;
        done_now = c_q.req && cpu_done;
        case (c_q.st)
            ST_IDLE: begin
                if (frame_vld && (frame_code == CODE_W'(READ_CODE))) begin
                    c_d.st        = ST_WAIT;
                    c_d.cnt       = '0;
                    c_d.req       = 1'b1;
                    c_d.done_seen = 1'b0;
                    c_d.addr      = frame_addr;
                end
            end
            ST_WAIT: begin
                if (c_q.cnt < CNT_W'(MIN_DLY - 1))
                    c_d.cnt = c_q.cnt + 1'b1;
                if (done_now) begin
                    c_d.req       = 1'b0;
                    c_d.done_seen = 1'b1;
                    c_d.rdata     = cpu_rdata;
                    c_d.status    = STAT_OK;
                end else if (c_q.req && cpu_stop) begin
                    c_d.req    = 1'b0;
                    c_d.status = STAT_DISCARD;
                    c_d.st     = ST_IDLE;
                end
                if ((c_q.done_seen || done_now) &&
                    (c_q.cnt == CNT_W'(MIN_DLY - 1))) begin
                    c_d.st  = ST_LOW;
                    c_d.cnt = '0;
                end
            end
            ST_LOW: begin
                if (c_q.cnt == CNT_W'(LOW_W - 1)) c_d.st = ST_SPEED;
                else                               c_d.cnt = c_q.cnt + 1'b1;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q        <= '0;
            c_q.st     <= ST_IDLE;
            c_q.status <= STAT_OK;
        end else begin
            c_q <= c_d;
        end
    end

    assign accept_en  = (c_q.st == ST_IDLE);
    assign drive_low  = (c_q.st == ST_LOW);
    assign drive_high = (c_q.st == ST_SPEED);
    assign cpu_req    = c_q.req;
    assign cpu_addr   = c_q.addr;
    assign rd_byte    = c_q.rdata;
    assign status     = c_q.status;

    p_drive_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(drive_low && drive_high));
    p_speed_after_low_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(drive_low) |-> drive_high);
    p_speed_single_r5: assert property (@(posedge clk) disable iff (rst)
        drive_high |=> !drive_high && !drive_low);
    p_req_drop_r2: assert property (@(posedge clk) disable iff (rst)
        cpu_req && cpu_done |=> !cpu_req && status == STAT_OK);
    p_stop_discard_r7: assert property (@(posedge clk) disable iff (rst)
        cpu_req && cpu_stop && !cpu_done |=> !cpu_req && status == STAT_DISCARD && !drive_low);
    p_rd_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !(cpu_req && cpu_done) |=> $stable(rd_byte));
    p_low_after_wait_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_low) |-> !cpu_req && !$past(drive_high));
endmodule

// File: rtl/dbg_ack_top.sv
module dbg_ack_top #(
    parameter int         CODE_W    = 8,
    parameter int         ADDR_W    = 16,
    parameter logic [7:0] READ_CODE = 8'h39,
    parameter int         MIN_DLY   = 32,
    parameter int         LOW_W     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_stb,
    input  logic              pin_in,
    input  logic              cpu_done,
    input  logic              cpu_stop,
    input  logic [7:0]        cpu_rdata,
    output logic              pin_drive_low,
    output logic              pin_drive_high,
    output logic              cpu_req,
    output logic [ADDR_W-1:0] cpu_addr,
    output logic [7:0]        rd_byte,
    output logic [2:0]        cmd_status
);
    logic              accept_en;
    logic              frame_vld;
    logic [CODE_W-1:0] frame_code;
    logic [ADDR_W-1:0] frame_addr;

    dbg_cmd_shift #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .accept_en  (accept_en),
        .bit_stb    (bit_stb),
        .bit_val    (pin_in),
        .frame_vld  (frame_vld),
        .frame_code (frame_code),
        .frame_addr (frame_addr)
    );

    dbg_ack_ctrl #(
        .CODE_W(CODE_W), .ADDR_W(ADDR_W), .DATA_W(8),
        .READ_CODE(READ_CODE), .MIN_DLY(MIN_DLY), .LOW_W(LOW_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .frame_vld  (frame_vld),
        .frame_code (frame_code),
        .frame_addr (frame_addr),
        .cpu_done   (cpu_done),
        .cpu_stop   (cpu_stop),
        .cpu_rdata  (cpu_rdata),
        .accept_en  (accept_en),
        .drive_low  (pin_drive_low),
        .drive_high (pin_drive_high),
        .cpu_req    (cpu_req),
        .cpu_addr   (cpu_addr),
        .rd_byte    (rd_byte),
        .status     (cmd_status)
    );
endmodule

// File: tb/dbg_ack_top_test.sv
module dbg_ack_top_test;
    localparam int ADDR_W = 16;
    localparam logic [7:0] RD_CODE = 8'h39;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_stb = 1'b0, pin_in = 1'b0, cpu_done = 1'b0, cpu_stop = 1'b0;
    logic [7:0] cpu_rdata = 8'h00;
    logic pin_drive_low, pin_drive_high, cpu_req;
    logic [ADDR_W-1:0] cpu_addr;
    logic [7:0] rd_byte;
    logic [2:0] cmd_status;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        int         at;
        logic [7:0] data;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dbg_ack_top #(.ADDR_W(ADDR_W), .READ_CODE(RD_CODE)) uut (
        .clk(clk), .rst(rst), .bit_stb(bit_stb), .pin_in(pin_in),
        .cpu_done(cpu_done), .cpu_stop(cpu_stop), .cpu_rdata(cpu_rdata),
        .pin_drive_low(pin_drive_low), .pin_drive_high(pin_drive_high),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr), .rd_byte(rd_byte),
        .cmd_status(cmd_status)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // monitor: pops expected acknowledges and measures pulse shape (R4, R5, R6)
    logic prev_low = 1'b0;
    int   low_len = 0;
    bit   want_idle = 1'b0;
    exp_t cur;
    always @(negedge clk) begin
        if (!rst) begin
            if (pin_drive_low && pin_drive_high)
                check(1'b0, "R6", 1, 0);
            if (want_idle) begin
                check(!pin_drive_high && !pin_drive_low, "R5", int'(pin_drive_high), 0);
                want_idle = 1'b0;
            end
            if (pin_drive_low && !prev_low) begin
                low_len = 1;
                if (q.size() == 0) begin
                    check(1'b0, "R9", 1, 0);
                end else begin
                    cur = q.pop_front();
                    check(cyc == cur.at, "R4", cyc, cur.at);
                    check(rd_byte == cur.data, "R3", int'(rd_byte), int'(cur.data));
                end
            end else if (pin_drive_low) begin
                low_len++;
            end else if (prev_low) begin
                check(low_len == 16, "R5", low_len, 16);
                check(pin_drive_high, "R5", int'(pin_drive_high), 1);
                want_idle = 1'b1;
            end
            prev_low = pin_drive_low;
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            check(1'b0, "watchdog", cyc, 150000);
            finish_run();
        end
    end

    // returns index of the edge that takes the last bit
    task automatic send_frame(input logic [7:0] code, input logic [ADDR_W-1:0] addr, output int c0);
        logic [8+ADDR_W-1:0] w;
        w = {code, addr};
        for (int i = 8 + ADDR_W - 1; i >= 0; i--) begin
            @(negedge clk);
            bit_stb = 1'b1;
            pin_in  = w[i];
            c0      = cyc + 1;
            @(negedge clk);
            bit_stb = 1'b0;
            pin_in  = ~w[i];
        end
    endtask

    task automatic wait_drain();
        int n = 0;
        while ((q.size() != 0 || pin_drive_low || pin_drive_high || want_idle) && n < 500) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] addr, input logic [7:0] data,
                           input int lat, input bit strays);
        int c0, cd, tgt;
        exp_t e;
        send_frame(RD_CODE, addr, c0);
        // after send_frame returns we sit at negedge with cyc == c0
        check(cpu_req == 1'b1, "R1", int'(cpu_req), 1);
        check(cpu_addr == addr, "R1", int'(cpu_addr), int'(addr));
        if (strays) begin
            for (int k = 0; k < 4; k++) begin
                bit_stb = 1'b1;
                pin_in  = k[0];
                @(negedge clk);
                bit_stb = 1'b0;
            end
        end
        while (lat > 0) begin
            check(pin_drive_low == 1'b0, "R4", int'(pin_drive_low), 0);
            @(negedge clk);
            lat--;
        end
        check(cpu_req == 1'b1, "R2", int'(cpu_req), 1);
        cpu_done  = 1'b1;
        cpu_rdata = data;
        cd        = cyc + 1;
        tgt       = (c0 + 32 > cd) ? c0 + 32 : cd;
        e.at      = tgt;
        e.data    = data;
        q.push_back(e);
        @(negedge clk);
        cpu_done  = 1'b0;
        cpu_rdata = ~data;
        check(cpu_req == 1'b0, "R2", int'(cpu_req), 0);
        check(cmd_status == 3'b000, "R8", int'(cmd_status), 0);
        wait_drain();
        check(q.size() == 0, "R4", q.size(), 0);
        check(rd_byte == data, "R3", int'(rd_byte), int'(data));
    endtask

    initial begin
        int c0;
        repeat (3) @(negedge clk);
        // R11: reset state
        check(pin_drive_low == 1'b0 && pin_drive_high == 1'b0, "R11", int'(pin_drive_low), 0);
        check(cpu_req == 1'b0, "R11", int'(cpu_req), 0);
        check(cmd_status == 3'b000, "R11", int'(cmd_status), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // fast CPU: quiet interval decides the edge (R4)
        do_read(16'hA55A, 8'h3C, 2, 1'b0);
        // slow CPU with stray strobes during the wait (R10, R4)
        do_read(16'h1234, 8'hC7, 45, 1'b1);
        // stray strobes must not have shifted anything in: new address decodes (R10)
        do_read(16'h0F0F, 8'h81, 5, 1'b0);

        // stop mode before completion (R7, R8)
        send_frame(RD_CODE, 16'hBEEF, c0);
        check(cpu_req == 1'b1, "R1", int'(cpu_req), 1);
        repeat (4) @(negedge clk);
        cpu_stop = 1'b1;
        @(negedge clk);
        cpu_stop = 1'b0;
        check(cpu_req == 1'b0, "R7", int'(cpu_req), 0);
        check(cmd_status == 3'b001, "R7", int'(cmd_status), 1);
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (pin_drive_low || pin_drive_high) check(1'b0, "R7", 1, 0);
        end
        check(rd_byte == 8'h81, "R3", int'(rd_byte), 8'h81);

        // foreign code: no request, status kept (R9, R8, R3)
        send_frame(8'h5A, 16'h2222, c0);
        for (int k = 0; k < 50; k++) begin
            if (cpu_req) check(1'b0, "R9", 1, 0);
            @(negedge clk);
        end
        check(cmd_status == 3'b001, "R8", int'(cmd_status), 1);
        check(rd_byte == 8'h81, "R3", int'(rd_byte), 8'h81);

        // later success clears status (R8)
        do_read(16'h7E01, 8'h5B, 10, 1'b0);
        check(cmd_status == 3'b000, "R8", int'(cmd_status), 0);

        // reset mid-request releases everything (R11)
        send_frame(RD_CODE, 16'h4444, c0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(cpu_req == 1'b0, "R11", int'(cpu_req), 0);
        check(cmd_status == 3'b000, "R11", int'(cmd_status), 0);
        repeat (50) @(negedge clk);
        check(q.size() == 0, "R11", q.size(), 0);
        finish_run();
    end
endmodule